// File: doc/BRIEF.md
# Synchronous Serial Word Shifter

This block moves 8-bit words over a three-wire clocked serial link: a serial clock, a data output and a data input. It can run as clock master, where it makes the serial clock from a one-cycle enable tick, or as clock slave, where an external clock enters through a two-flop synchroniser before edge detection. Each word can go out and come in either least-significant bit first or most-significant bit first. The order is captured when a word starts, so a change while a word is moving does not touch that word.

Toward the processor the block has a transmit holding register, a receive holding register and status flags. With double buffering enabled, the transmit holding register empties as soon as its word is moved into the shifter. This lets the next word be written while the current one is still shifting. A finished receive word that meets a full receive register is dropped, and the older word is kept. With double buffering disabled, the transmit register stays occupied until its word has fully shifted, and a new receive word overwrites the old one.

As slave, the block cannot hold the clock back. It therefore reports a receive overrun, and when double buffering is enabled it also reports a transmit underrun. As master, it only starts a word when there is data to send and room to receive, so neither error can happen and both flags read 0. The framing error output is tied to 0 because there is no asynchronous framing in this block.

Top module: `sio_shifter`

## Requirements
- R1: The serial clock idles high. The data output changes only on falling serial clock edges, and the data input is sampled on rising edges. In slave mode `sclk_out` stays high.
- R2: With `cfg_lsb_first`=1, bit 0 of a word is sent and received first. With 0, bit 7 is first. In both cases the first bit appears on `sdo` at the word's first falling edge.
- R3: The bit order is captured at the first falling edge of a word. Changing `cfg_lsb_first` in the middle of a word has no effect on that word.
- R4: As master, each `tick` makes one half period of the serial clock, so a word takes 8 falling edges. A word starts only when the transmit register is full and the receive register is empty.
- R5: As slave, `sclk_in` passes through a two-flop synchroniser. Each synchronised falling edge shifts out one bit, and each rising edge samples one bit.
- R6: A write is accepted only when `tx_empty`=1. A write while the register is full is ignored, and the word already held is the one sent.
- R7: With `cfg_dbuf`=1, `tx_empty` returns to 1 when a word starts. With `cfg_dbuf`=0, it returns to 1 only when that word has finished.
- R8: A finished word is placed in `rd_data` and sets `rx_full`. A `rd_strobe` pulse clears `rx_full`.
- R9: As slave, a word that finishes while `rx_full`=1 sets `err_overrun`. With double buffering on, the old word is kept; with it off, the new word replaces it.
- R10: As slave, a word that starts with no transmit data shifts out all ones. If double buffering is on, it also sets `err_underrun`; if it is off, `err_underrun` stays 0.
- R11: `err_overrun` and `err_underrun` read 0 in master mode, and `err_clr` clears both. `err_framing` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 1: serial clock comes from `sclk_in` (slave); 0: generated (master) |
| cfg_dbuf | input | 1 | 1: double buffering enabled |
| cfg_lsb_first | input | 1 | 1: LSB first; 0: MSB first |
| tick | input | 1 | Half-period enable for the master clock |
| wr_valid | input | 1 | Write pulse for the transmit register |
| wr_data | input | 8 | Transmit word |
| rd_strobe | input | 1 | Read pulse; clears `rx_full` |
| rd_data | output | 8 | Receive holding register |
| err_clr | input | 1 | Clears the error flags |
| rx_full | output | 1 | Receive register holds unread data |
| tx_empty | output | 1 | Transmit register can accept a word |
| err_overrun | output | 1 | Receive overrun (slave mode) |
| err_underrun | output | 1 | Transmit underrun (slave mode, double buffered) |
| err_framing | output | 1 | Framing error, always 0 |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
Words are looped from `sdo` back to `sdi`, so a word read back equal to the written word shows that sending and receiving used the same captured order, even when the order input is flipped mid-word. Words with a single set bit, such as 0x01, tell the two bit orders apart at the first shifted bit. A free-running pseudo-random `sdi` exercises the receive assembly in both orders and at several tick rates. In slave mode, sequences with a missing write or a missing read separate the single-buffered and double-buffered handling of underrun and overrun.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int unsigned SIO_W = 8;

  typedef logic [SIO_W-1:0] sio_word_t;

  // bit placed on the line for word w under order lsb
  function automatic logic pick_bit(input sio_word_t w, input logic lsb);
    return lsb ? w[0] : w[SIO_W-1];
  endfunction

  // word left after the outgoing bit has been removed (ones fill in)
  function automatic sio_word_t drop_bit(input sio_word_t w, input logic lsb);
    return lsb ? {1'b1, w[SIO_W-1:1]} : {w[SIO_W-2:0], 1'b1};
  endfunction

  // receive word after one more line bit b has been taken in
  function automatic sio_word_t take_bit(input sio_word_t w, input logic b,
                                         input logic lsb);
    return lsb ? {b, w[SIO_W-1:1]} : {w[SIO_W-2:0], b};
  endfunction

endpackage

// File: rtl/sio_clk_gen.sv
module sio_clk_gen #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ext,
  input  logic tick,
  input  logic sclk_in,
  input  logic in_word,
  input  logic can_start,
  output logic sclk_out,
  output logic fall_ev,
  output logic rise_ev
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   sclk_q;
  logic                   ext_fall, ext_rise;
  logic                   int_fall, int_rise;

  // external clock: synchroniser chain plus one history stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q[0] <= sclk_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign ext_fall = prev_q & ~sync_q[LAST];
  assign ext_rise = ~prev_q & sync_q[LAST];

  // internal clock: a tick flips the line, a new word needs data and room
  assign int_fall = ~cfg_ext & tick & sclk_q & (in_word | can_start);
  assign int_rise = ~cfg_ext & tick & ~sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sclk_q <= 1'b1;
    else if (int_fall) sclk_q <= 1'b0;
    else if (int_rise) sclk_q <= 1'b1;
  end

  assign fall_ev  = cfg_ext ? ext_fall : int_fall;
  assign rise_ev  = cfg_ext ? ext_rise : int_rise;
  assign sclk_out = sclk_q;

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext && !in_word) |-> sclk_q);

  p_edges_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev && rise_ev));

endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core
  import sio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_lsb,
  input  logic      fall_ev,
  input  logic      rise_ev,
  input  logic      txb_full,
  input  sio_word_t txb,
  input  logic      sdi,
  output logic      sdo,
  output logic      in_word,
  output logic      word_start,
  output logic      word_end,
  output sio_word_t rx_word
);

  localparam int unsigned CNT_W = $clog2(SIO_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SIO_W - 1);

  logic [CNT_W-1:0] bit_q;
  logic             busy_q;
  logic             ord_q;
  logic             sdo_q;
  sio_word_t        tx_sh;
  sio_word_t        rx_sh;
  sio_word_t        load_w;
  sio_word_t        cur_w;
  logic             cur_o;
  sio_word_t        rx_next;

  assign word_start = fall_ev & ~busy_q;
  assign load_w     = txb_full ? txb : '1;
  assign cur_w      = word_start ? load_w : tx_sh;
  assign cur_o      = word_start ? cfg_lsb : ord_q;
  assign rx_next    = take_bit(rx_sh, sdi, ord_q);
  assign word_end   = rise_ev & busy_q & (bit_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      busy_q <= 1'b0;
      ord_q  <= 1'b0;
      sdo_q  <= 1'b1;
      tx_sh  <= '1;
      rx_sh  <= '0;
    end else begin
      if (fall_ev) begin
        sdo_q <= pick_bit(cur_w, cur_o);
        tx_sh <= drop_bit(cur_w, cur_o);
        ord_q <= cur_o;
        if (word_start) begin
          busy_q <= 1'b1;
          bit_q  <= '0;
        end
      end
      if (rise_ev && busy_q) begin
        rx_sh <= rx_next;
        if (bit_q == LAST_BIT) begin
          busy_q <= 1'b0;
          bit_q  <= '0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign sdo     = sdo_q;
  assign in_word = busy_q;
  assign rx_word = rx_next;

  p_order_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !word_end) |=> $stable(ord_q));

  p_end_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> !busy_q);

  p_line_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> $stable(sdo_q));

endmodule

// File: rtl/sio_buffers.sv
module sio_buffers
  import sio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_ext,
  input  logic      cfg_dbuf,
  input  logic      wr_valid,
  input  sio_word_t wr_data,
  input  logic      rd_strobe,
  input  logic      err_clr,
  input  logic      word_start,
  input  logic      word_end,
  input  sio_word_t rx_word,
  output sio_word_t txb,
  output logic      txb_full,
  output logic      can_start,
  output sio_word_t rd_data,
  output logic      rx_full,
  output logic      tx_empty,
  output logic      err_overrun,
  output logic      err_underrun
);

  sio_word_t txb_q, rxb_q;
  logic      txf_q, rxf_q, took_q, ovr_q, udr_q;
  logic      release_tx, accept_wr, eff_full, ovr_ev, udr_ev, store_rx;

  assign release_tx = (word_start & txf_q & cfg_dbuf) |
                      (word_end & took_q & ~cfg_dbuf);
  assign accept_wr  = wr_valid & ~txf_q;
  assign eff_full   = rxf_q & ~rd_strobe;
  assign ovr_ev     = word_end & eff_full & cfg_ext;
  assign udr_ev     = word_start & ~txf_q & cfg_ext & cfg_dbuf;
  assign store_rx   = word_end & (~eff_full | ~cfg_dbuf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q  <= '0;
      txf_q  <= 1'b0;
      took_q <= 1'b0;
      rxb_q  <= '0;
      rxf_q  <= 1'b0;
      ovr_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      if (word_start) took_q <= txf_q;
      if (accept_wr)  txb_q  <= wr_data;
      txf_q <= (txf_q & ~release_tx) | accept_wr;
      if (store_rx)   rxb_q  <= rx_word;
      if (word_end)       rxf_q <= 1'b1;
      else if (rd_strobe) rxf_q <= 1'b0;
      ovr_q <= (ovr_q & ~err_clr) | ovr_ev;
      udr_q <= (udr_q & ~err_clr) | udr_ev;
    end
  end

  assign txb          = txb_q;
  assign txb_full     = txf_q;
  assign can_start    = txf_q & ~rxf_q;
  assign rd_data      = rxb_q;
  assign rx_full      = rxf_q;
  assign tx_empty     = ~txf_q;
  assign err_overrun  = ovr_q & cfg_ext;
  assign err_underrun = udr_q & cfg_ext & cfg_dbuf;

  p_start_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && !cfg_ext) |-> txf_q);

  p_master_has_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !cfg_ext) |-> !rxf_q);

  p_full_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> rxf_q);

  p_hold_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && txf_q) |=> $stable(txb_q));

  p_underrun_dbuf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_q) |-> $past(cfg_ext && cfg_dbuf));

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_clk,
  input  logic             cfg_dbuf,
  input  logic             cfg_lsb_first,
  input  logic             tick,
  input  logic             wr_valid,
  input  logic [SIO_W-1:0] wr_data,
  input  logic             rd_strobe,
  output logic [SIO_W-1:0] rd_data,
  input  logic             err_clr,
  output logic             rx_full,
  output logic             tx_empty,
  output logic             err_overrun,
  output logic             err_underrun,
  output logic             err_framing,
  input  logic             sclk_in,
  output logic             sclk_out,
  input  logic             sdi,
  output logic             sdo
);

  logic      fall_ev, rise_ev, in_word, can_start;
  logic      word_start, word_end, txb_full;
  sio_word_t txb, rx_word;

  sio_clk_gen #(.SYNC_STAGES(SYNC_STAGES)) clk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_ext   (cfg_ext_clk),
    .tick      (tick),
    .sclk_in   (sclk_in),
    .in_word   (in_word),
    .can_start (can_start),
    .sclk_out  (sclk_out),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev)
  );

  sio_shift_core core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_lsb    (cfg_lsb_first),
    .fall_ev    (fall_ev),
    .rise_ev    (rise_ev),
    .txb_full   (txb_full),
    .txb        (txb),
    .sdi        (sdi),
    .sdo        (sdo),
    .in_word    (in_word),
    .word_start (word_start),
    .word_end   (word_end),
    .rx_word    (rx_word)
  );

  sio_buffers buf_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ext      (cfg_ext_clk),
    .cfg_dbuf     (cfg_dbuf),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .rd_strobe    (rd_strobe),
    .err_clr      (err_clr),
    .word_start   (word_start),
    .word_end     (word_end),
    .rx_word      (rx_word),
    .txb          (txb),
    .txb_full     (txb_full),
    .can_start    (can_start),
    .rd_data      (rd_data),
    .rx_full      (rx_full),
    .tx_empty     (tx_empty),
    .err_overrun  (err_overrun),
    .err_underrun (err_underrun)
  );

  // synchronous link: no stop bit exists, so no framing error
  assign err_framing = 1'b0;

endmodule

// File: tb/sio_shifter_tb_top.sv
module sio_shifter_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_ext_clk = 1'b0, cfg_dbuf = 1'b0, cfg_lsb_first = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_valid = 1'b0, rd_strobe = 1'b0, err_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sclk_in = 1'b1;
  logic       loop = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  int         tdiv = 1;
  int         tcnt = 0;
  logic       tick, sdi;
  logic [7:0] rd_data;
  logic       rx_full, tx_empty, err_overrun, err_underrun, err_framing;
  logic       sclk_out, sdo;

  int vec = 0, errs = 0, nfall = 0;
  logic prev_sclk = 1'b1;
  bit done = 0;

  assign tick = tick_en && (tcnt == 0);
  assign sdi  = loop ? sdo : lfsr[0];

  sio_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_dbuf(cfg_dbuf),
    .cfg_lsb_first(cfg_lsb_first), .tick(tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .err_clr(err_clr), .rx_full(rx_full), .tx_empty(tx_empty),
    .err_overrun(err_overrun), .err_underrun(err_underrun),
    .err_framing(err_framing), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sdi(sdi), .sdo(sdo)
  );

  always @(negedge clk) begin
    tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  end

  // ---------------- behavioural reference model ----------------
  bit         m_sclk = 1, m_sdo = 1, m_busy = 0, m_took = 0, m_ord = 0;
  bit         m_rxf = 0, m_ovr = 0, m_udr = 0;
  logic [7:0] m_word = 8'hFF, m_acc = 8'h00, m_rxv = 8'h00;
  int         m_sent = 0, m_got = 0;
  logic [7:0] txq[$];
  bit         hs [3] = '{1, 1, 1};
  bit         f, r, st, en, acc;
  int         pre;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sclk = 1; m_sdo = 1; m_busy = 0; m_took = 0; m_ord = 0;
      m_rxf = 0; m_ovr = 0; m_udr = 0; m_rxv = 8'h00;
      txq.delete();
      hs = '{1, 1, 1};
    end else begin
      if (cfg_ext_clk) begin
        f = hs[2] && !hs[1];
        r = !hs[2] && hs[1];
      end else begin
        f = tick && m_sclk && (m_busy || (txq.size() > 0 && !m_rxf));
        r = tick && !m_sclk;
      end
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = sclk_in;
      pre = txq.size();
      acc = wr_valid && (pre == 0);
      if (err_clr) begin m_ovr = 0; m_udr = 0; end
      st = f && !m_busy;
      en = 0;
      if (f) begin
        if (st) begin
          if (pre > 0) begin
            m_word = txq[0]; m_took = 1;
            if (cfg_dbuf) void'(txq.pop_front());
          end else begin
            m_word = 8'hFF; m_took = 0;
            if (cfg_ext_clk && cfg_dbuf) m_udr = 1;
          end
          m_ord = cfg_lsb_first; m_busy = 1; m_sent = 0; m_got = 0; m_acc = 8'h00;
        end
        m_sdo = m_ord ? m_word[m_sent] : m_word[7 - m_sent];
        m_sent++;
        if (!cfg_ext_clk) m_sclk = 0;
      end
      if (r) begin
        if (!cfg_ext_clk) m_sclk = 1;
        if (m_busy) begin
          if (m_ord) m_acc[m_got] = sdi; else m_acc[7 - m_got] = sdi;
          m_got++;
          if (m_got == 8) begin
            en = 1; m_busy = 0;
            if (!cfg_dbuf && m_took) void'(txq.pop_front());
          end
        end
      end
      if (acc) txq.push_back(wr_data);
      if (en) begin
        if (!(m_rxf && !rd_strobe)) begin m_rxv = m_acc; m_rxf = 1; end
        else begin
          if (cfg_ext_clk) m_ovr = 1;
          if (!cfg_dbuf) m_rxv = m_acc;
        end
      end else if (rd_strobe) m_rxf = 0;
    end
  end

  task automatic chk(input string req, input string name, input int act, input int exp);
    vec++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, name, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (sclk_out === 1'b0 && prev_sclk === 1'b1) nfall++;
    prev_sclk <= sclk_out;
    if (rst_n) begin
      chk("R1", "sclk_out", sclk_out, m_sclk);
      chk("R2", "sdo", sdo, m_sdo);
      chk("R6", "tx_empty", tx_empty, txq.size() == 0);
      chk("R8", "rx_full", rx_full, m_rxf);
      chk("R2", "rd_data", rd_data, m_rxv);
      chk("R9", "err_overrun", err_overrun, m_ovr && cfg_ext_clk);
      chk("R10", "err_underrun", err_underrun, m_udr && cfg_ext_clk && cfg_dbuf);
      chk("R11", "err_framing", err_framing, 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic write_byte(input logic [7:0] b);
    wr_data = b; wr_valid = 1'b1; idle(1); wr_valid = 1'b0;
  endtask
  task automatic read_pulse();
    rd_strobe = 1'b1; idle(1); rd_strobe = 1'b0;
  endtask
  task automatic clr_pulse();
    err_clr = 1'b1; idle(1); err_clr = 1'b0;
  endtask
  task automatic tick_pulse();
    tick_en = 1'b1; idle(1); tick_en = 1'b0;
  endtask
  task automatic slave_word();
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0; idle(4);
      sclk_in = 1'b1; idle(4);
    end
    idle(6);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; vec++;
      $display("FAIL watchdog expired before the sequence ended");
      report();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // reset state
    chk("R1", "sclk_out after reset", sclk_out, 1);
    chk("R1", "sdo after reset", sdo, 1);
    chk("R6", "tx_empty after reset", tx_empty, 1);
    chk("R8", "rx_full after reset", rx_full, 0);
    chk("R11", "err_framing after reset", err_framing, 0);

    // R6: second write while full is ignored (master, single buffer)
    write_byte(8'hA5);
    write_byte(8'h3C);
    chk("R6", "tx_empty held", tx_empty, 0);
    tick_en = 1'b1; idle(40);
    chk("R6", "first word kept", rd_data, 8'hA5);
    chk("R8", "rx_full set", rx_full, 1);
    chk("R6", "tx_empty after word", tx_empty, 1);
    read_pulse(); idle(1);
    chk("R8", "rx_full cleared", rx_full, 0);

    // R4: eight falling edges per word
    nfall = 0;
    write_byte(8'h5B); idle(40);
    chk("R4", "falls per word", nfall, 8);
    chk("R4", "loopback word", rd_data, 8'h5B);
    read_pulse();

    // R2: first bit on the line for each order
    tick_en = 1'b0; cfg_lsb_first = 1'b1;
    write_byte(8'h01); idle(1); tick_pulse();
    chk("R2", "lsb-first first bit", sdo, 1);
    tick_en = 1'b1; idle(40);
    chk("R2", "lsb-first loopback", rd_data, 8'h01);
    read_pulse();
    tick_en = 1'b0; cfg_lsb_first = 1'b0;
    write_byte(8'h01); idle(1); tick_pulse();
    chk("R2", "msb-first first bit", sdo, 0);
    tick_en = 1'b1; idle(40); read_pulse();

    // R2: pseudo-random input, both orders, slower ticks
    loop = 1'b0; tdiv = 2;
    for (int k = 0; k < 4; k++) begin
      cfg_lsb_first = k[0];
      write_byte(8'h17 + 8'(k * 37)); idle(50);
      chk("R2", "random rx present", rx_full, 1);
      read_pulse();
    end
    loop = 1'b1;

    // R3: order change mid-word has no effect
    tdiv = 3; cfg_lsb_first = 1'b0;
    write_byte(8'h96); idle(12);
    cfg_lsb_first = 1'b1; idle(60);
    chk("R3", "order held", rd_data, 8'h96);
    read_pulse(); cfg_lsb_first = 1'b0;

    // R7: when the transmit register frees up
    cfg_dbuf = 1'b1;
    write_byte(8'h11); idle(8);
    chk("R7", "dbuf frees at start", tx_empty, 1);
    idle(60); read_pulse();
    cfg_dbuf = 1'b0;
    write_byte(8'h22); idle(8);
    chk("R7", "single holds mid-word", tx_empty, 0);
    idle(60);
    chk("R7", "single frees at end", tx_empty, 1);
    read_pulse();

    // slave mode
    tick_en = 1'b0; tdiv = 1; cfg_ext_clk = 1'b1; cfg_dbuf = 1'b1; idle(2);
    slave_word();
    chk("R1", "slave leaves sclk_out high", sclk_out, 1);
    chk("R10", "underrun flagged", err_underrun, 1);
    chk("R10", "ones sent on underrun", rd_data, 8'hFF);
    read_pulse(); clr_pulse(); idle(1);
    chk("R11", "err_clr clears underrun", err_underrun, 0);
    cfg_dbuf = 1'b0;
    slave_word();
    chk("R10", "no underrun single", err_underrun, 0);
    chk("R10", "ones sent single", rd_data, 8'hFF);
    read_pulse();

    // R5: slave loopback, lsb first
    cfg_dbuf = 1'b1; cfg_lsb_first = 1'b1;
    write_byte(8'hE7); slave_word();
    chk("R5", "slave loopback", rd_data, 8'hE7);
    read_pulse();
    loop = 1'b0; write_byte(8'h4D); slave_word();
    chk("R5", "slave random rx", rx_full, 1);
    read_pulse(); loop = 1'b1; cfg_lsb_first = 1'b0;

    // R9: overrun, double then single buffered
    write_byte(8'h5A); slave_word();
    write_byte(8'hC3); slave_word();
    chk("R9", "overrun dbuf", err_overrun, 1);
    chk("R9", "dbuf keeps old", rd_data, 8'h5A);
    read_pulse(); clr_pulse();
    cfg_dbuf = 1'b0;
    write_byte(8'h5A); slave_word();
    write_byte(8'hC3); slave_word();
    chk("R9", "overrun single", err_overrun, 1);
    chk("R9", "single takes new", rd_data, 8'hC3);
    cfg_ext_clk = 1'b0; idle(1);
    chk("R11", "overrun masked as master", err_overrun, 0);
    chk("R11", "underrun masked as master", err_underrun, 0);
    clr_pulse(); read_pulse(); idle(4);
    chk("R11", "framing stays 0", err_framing, 0);

    done = 1;
    report();
    $finish;
  end

endmodule